// File: doc/BRIEF.md
# Duty-Cycle Coded Bus Transmitter with Bitwise Arbitration

This block places a byte-wide message on a single-wire, wired-AND vehicle bus. Every bit has the same length, `cfg_div` system clocks. The value of a bit is carried by how long the node leaves the line released before it pulls it low. A `0` is released for the first half of the period and pulled low for the rest. A `1` is released for the first three quarters and pulled low for the last quarter. A low level from any node overrides a released line. Bytes are sent most significant bit first, so the priority field at the head of a frame is compared before anything else.

Before it sends the first bit of a frame, the block waits until the line has been released for a programmable number of whole bit periods. During each bit it sends, the block samples the line at five eighths of the period. At that point a `0` already pulls the line low and a `1` still leaves it released. If the node sent a `1` and finds the line low, a node with a lower header value has won. The block then releases the line at once, raises a sticky lost flag, and discards the rest of the message. The winning frame is left intact.

Upstream logic supplies bytes through a valid/ready handshake, with a marker on the final byte. The block reports a one-cycle completion pulse, the sticky lost flag, and a busy level.

Top module: `pwm_bus_tx`

## Requirements
- R1: One bit lasts exactly `cfg_div` clocks (`cfg_div` >= 8). Bits leave MSB first. When the next byte is already valid at the end of a byte, it follows with no gap.
- R2: For a `0` bit, `bus_drive_low` is 0 for the first floor(`cfg_div`/2) clocks of the period and 1 for the remaining clocks.
- R3: For a `1` bit, `bus_drive_low` is 0 for the first floor(3·`cfg_div`/4) clocks of the period and 1 for the remaining clocks.
- R4: When `s_valid` is seen while the block is idle, it waits until `bus_sense` has been 1 for `cfg_idle_bits`·`cfg_div` consecutive clocks. Any low clock restarts the count. The first byte is then accepted and sent, and a value of 0 means no wait.
- R5: During a `1` bit, `bus_sense` is sampled at clock floor(5·`cfg_div`/8) of the period. If it reads 0 there, the next cycle has `bus_drive_low`=0, `arb_lost`=1 and `busy`=0.
- R6: After a loss, the remaining bytes of the message are accepted with `s_ready`=1 and discarded, up to and including the byte marked `s_last`. The line stays released throughout.
- R7: `done` is a one-cycle pulse in the cycle after the final period of a byte marked `s_last`. It never follows a lost frame.
- R8: `busy` is 0 out of reset. It is 1 from the cycle after an idle `s_valid` until completion or loss.
- R9: `arb_lost` stays 1 until `s_valid` is next seen in the idle state, and clears in the following cycle.
- R10: If the next byte is not valid when a byte ends, the line is released, `s_ready` stays 1 until the byte arrives, and its first bit period starts in the cycle after the handshake.
- R11: `s_ready` is 1 only while waiting for a byte, in the last clock of a byte that is not the final one, or while discarding. A byte is taken only when `s_valid` and `s_ready` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_div | input | DIV_W | Bit period in clocks |
| cfg_idle_bits | input | IDLE_W | Idle bit periods required before a frame |
| s_data | input | 8 | Byte to send |
| s_valid | input | 1 | Byte available |
| s_last | input | 1 | Byte is the final one of the message |
| s_ready | output | 1 | Byte taken this cycle when valid |
| bus_drive_low | output | 1 | 1 pulls the shared line low |
| bus_sense | input | 1 | Sensed line level, 1 = released |
| done | output | 1 | Frame sent in full, one-cycle pulse |
| arb_lost | output | 1 | Sticky lost-arbitration flag |
| busy | output | 1 | Frame attempt in progress |

## Verification
A wrong bit counter, wrong shift register contents or wrong threshold appears on `bus_drive_low` in the same bit period. The low edge lands one or more clocks away from the half or three-quarter mark, and the error shows within `cfg_div` clocks. A wrong sample point or wrong arbitration state makes the block drop out when it should win, or keep driving after a dominant bit. That is visible on `arb_lost` and `busy` one cycle after the sample clock. A state machine that loses count of bytes shows up at the next byte boundary as a misplaced `s_ready`, a missing `done` pulse or an extra one. The reference model follows every clock, including one competing node and line noise during the idle wait, so any such difference is reported in the cycle it occurs.

// File: rtl/pwm_tx_pkg.sv
package pwm_tx_pkg;

    localparam int BYTE_W    = 8;
    localparam int BIT_IDX_W = $clog2(BYTE_W);

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_WAIT = 3'd1,
        ST_LOAD = 3'd2,
        ST_SEND = 3'd3,
        ST_DROP = 3'd4
    } tx_state_e;

    typedef struct packed {
        tx_state_e            st;
        logic [BYTE_W-1:0]    sh;
        logic [BIT_IDX_W-1:0] bitn;
        logic                 last;
        logic                 lost;
        logic                 done;
    } tx_regs_t;

endpackage

// File: rtl/pwm_tx_bit_timer.sv
module pwm_tx_bit_timer #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] cfg_div,
    output logic             at_end,
    output logic             at_sample,
    output logic             past_half,
    output logic             past_3q
);
    localparam int EXT_W = DIV_W + 3;

    logic [DIV_W-1:0] cnt_q, cnt_d;
    logic [EXT_W-1:0] cnt_ext, q3_pt, samp_pt;
    logic [DIV_W-1:0] half_pt;

    assign cnt_ext = EXT_W'(cnt_q);
    assign half_pt = cfg_div >> 1;
    assign q3_pt   = (EXT_W'(cfg_div) * EXT_W'(3)) >> 2;
    assign samp_pt = (EXT_W'(cfg_div) * EXT_W'(5)) >> 3;

    assign at_end    = (cnt_q == cfg_div - DIV_W'(1));
    assign at_sample = (cnt_ext == samp_pt);
    assign past_half = (cnt_q >= half_pt);
    assign past_3q   = (cnt_ext >= q3_pt);

    always_comb begin
        cnt_d = cnt_q;
        if (!run)        cnt_d = '0;
        else if (at_end) cnt_d = '0;
        else             cnt_d = cnt_q + DIV_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R1: the phase counter never leaves the programmed period
    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q < cfg_div));
    // R1: a stopped timer restarts its period from zero
    p_cnt_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0));
endmodule

// File: rtl/pwm_tx_idle_mon.sv
module pwm_tx_idle_mon #(
    parameter int DIV_W  = 16,
    parameter int IDLE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              bus_sense,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic [IDLE_W-1:0] cfg_idle_bits,
    output logic              idle_ok
);
    logic [DIV_W-1:0]  clk_q, clk_d;
    logic [IDLE_W-1:0] nb_q, nb_d;

    assign idle_ok = (nb_q == cfg_idle_bits);

    always_comb begin
        clk_d = clk_q;
        nb_d  = nb_q;
        if (!enable || !bus_sense) begin
            clk_d = '0;
            nb_d  = '0;
        end else if (!idle_ok) begin
            if (clk_q == cfg_div - DIV_W'(1)) begin
                clk_d = '0;
                nb_d  = nb_q + IDLE_W'(1);
            end else begin
                clk_d = clk_q + DIV_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_q <= '0;
            nb_q  <= '0;
        end else begin
            clk_q <= clk_d;
            nb_q  <= nb_d;
        end
    end

    // R4: a dominant level during the wait restarts the idle count
    p_idle_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !bus_sense) |=> (nb_q == '0 && clk_q == '0));
    // R4: the idle bit count never overshoots the programmed value
    p_idle_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        enable |-> (nb_q <= cfg_idle_bits));
endmodule

// File: rtl/pwm_bus_tx.sv
module pwm_bus_tx
    import pwm_tx_pkg::*;
#(
    parameter int DIV_W  = 16,
    parameter int IDLE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic [IDLE_W-1:0] cfg_idle_bits,
    input  logic [BYTE_W-1:0] s_data,
    input  logic              s_valid,
    input  logic              s_last,
    output logic              s_ready,
    output logic              bus_drive_low,
    input  logic              bus_sense,
    output logic              done,
    output logic              arb_lost,
    output logic              busy
);
    localparam logic [BIT_IDX_W-1:0] LAST_BIT = BIT_IDX_W'(BYTE_W - 1);

    tx_regs_t r_q, r_d;
    logic     t_end, t_samp, t_half, t_3q;
    logic     idle_ok;
    logic     run, waiting, byte_end;

    assign run      = (r_q.st == ST_SEND);
    assign waiting  = (r_q.st == ST_WAIT);
    assign byte_end = run && t_end && (r_q.bitn == LAST_BIT);

    pwm_tx_bit_timer #(.DIV_W(DIV_W)) i_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .cfg_div   (cfg_div),
        .at_end    (t_end),
        .at_sample (t_samp),
        .past_half (t_half),
        .past_3q   (t_3q)
    );

    pwm_tx_idle_mon #(.DIV_W(DIV_W), .IDLE_W(IDLE_W)) i_idle (
        .clk           (clk),
        .rst_n         (rst_n),
        .enable        (waiting),
        .bus_sense     (bus_sense),
        .cfg_div       (cfg_div),
        .cfg_idle_bits (cfg_idle_bits),
        .idle_ok       (idle_ok)
    );

    assign s_ready = (r_q.st == ST_LOAD) || (r_q.st == ST_DROP) ||
                     (byte_end && !r_q.last);

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (s_valid) begin
                    r_d.st   = ST_WAIT;
                    r_d.lost = 1'b0;
                end
            end
            ST_WAIT: begin
                if (idle_ok) r_d.st = ST_LOAD;
            end
            ST_LOAD: begin
                if (s_valid) begin
                    r_d.sh   = s_data;
                    r_d.last = s_last;
                    r_d.bitn = '0;
                    r_d.st   = ST_SEND;
                end
            end
            ST_SEND: begin
                if (t_samp && r_q.sh[BYTE_W-1] && !bus_sense) begin
                    r_d.lost = 1'b1;
                    r_d.st   = r_q.last ? ST_IDLE : ST_DROP;
                end else if (t_end) begin
                    if (r_q.bitn == LAST_BIT) begin
                        if (r_q.last) begin
                            r_d.st   = ST_IDLE;
                            r_d.done = 1'b1;
                        end else if (s_valid) begin
                            r_d.sh   = s_data;
                            r_d.last = s_last;
                            r_d.bitn = '0;
                        end else begin
                            r_d.st = ST_LOAD;
                        end
                    end else begin
                        r_d.sh   = {r_q.sh[BYTE_W-2:0], 1'b0};
                        r_d.bitn = r_q.bitn + BIT_IDX_W'(1);
                    end
                end
            end
            ST_DROP: begin
                if (s_valid && s_last) r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign bus_drive_low = run && (r_q.sh[BYTE_W-1] ? t_3q : t_half);
    assign done          = r_q.done;
    assign arb_lost      = r_q.lost;
    assign busy          = (r_q.st == ST_WAIT) || (r_q.st == ST_LOAD) ||
                           (r_q.st == ST_SEND);

    // R5: a fresh loss always leaves the line released
    p_lost_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arb_lost) |-> (!bus_drive_low && !busy));
    // R5: a loss follows only a recessive bit overridden on the line
    p_lost_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.lost) |-> ($past(r_q.st) == ST_SEND && !$past(bus_sense) &&
                             $past(r_q.sh[BYTE_W-1])));
    // R7: completion never coincides with a lost or ongoing attempt
    p_done_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!arb_lost && !busy));
    // R1: the byte in flight is held steady until its period boundary
    p_byte_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !t_end) |=> ($stable(r_q.sh) && $stable(r_q.bitn)));
    // R11: a byte taken while waiting starts its first bit next cycle
    p_take_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (s_ready && s_valid && r_q.st == ST_LOAD) |=> (r_q.st == ST_SEND));
endmodule

// File: tb/test_pwm_bus_tx.sv
module test_pwm_bus_tx;
    localparam int DIV_W  = 16;
    localparam int IDLE_W = 4;
    localparam int WDOG   = 150000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [DIV_W-1:0]  cfg_div;
    logic [IDLE_W-1:0] cfg_idle_bits;
    logic [7:0]        s_data = '0;
    logic              s_valid = 1'b0;
    logic              s_last = 1'b0;
    logic              s_ready, bus_drive_low, bus_sense, done, arb_lost, busy;
    logic              oth_low = 1'b0;
    logic              noise_low = 1'b0;

    always #2 clk = ~clk;

    int P = 16;
    int idle_cfg = 2;
    assign cfg_div       = DIV_W'(P);
    assign cfg_idle_bits = IDLE_W'(idle_cfg);
    assign bus_sense     = !(bus_drive_low || oth_low || noise_low);

    pwm_bus_tx #(.DIV_W(DIV_W), .IDLE_W(IDLE_W)) i_pwm_bus_tx (
        .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_idle_bits(cfg_idle_bits),
        .s_data(s_data), .s_valid(s_valid), .s_last(s_last), .s_ready(s_ready),
        .bus_drive_low(bus_drive_low), .bus_sense(bus_sense), .done(done),
        .arb_lost(arb_lost), .busy(busy)
    );

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int done_cnt = 0;
    bit finished = 0;

    // upstream byte stream: {last, data}
    logic [8:0] up_q[$];
    logic [7:0] comp_q[$];

    // behavioural reference: 0 idle, 1 idle-wait, 2 wait byte, 3 sending, 4 discarding
    int ms = 0, mcnt = 0, iclk = 0, ibit = 0, bitn = 0;
    logic [7:0] msh = '0;
    bit mlast = 0, mlost = 0, mdone = 0, first = 0, hs_pend = 0;
    // competing node
    bit comp_on = 0;
    int ccnt = 0, cbit = 0;
    logic [7:0] csh = '0;

    function automatic int half_pt();  return P / 2;       endfunction
    function automatic int q3_pt();    return (3 * P) / 4; endfunction
    function automatic int samp_pt();  return (5 * P) / 8; endfunction

    function automatic bit exp_ready();
        return (ms == 2) || (ms == 4) || (ms == 3 && mcnt == P - 1 && bitn == 7 && !mlast);
    endfunction
    function automatic bit exp_drive();
        return (ms == 3) && (mcnt >= (msh[7] ? q3_pt() : half_pt()));
    endfunction

    task automatic chk(string tag, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s at cycle %0d: act=%0b exp=%0b", tag, what, cyc, act, exp);
        end
    endtask

    task automatic finish_run();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    task automatic model_step();
        bit sense;
        bit rdy;
        int st0;
        sense = bus_sense;
        rdy   = exp_ready();
        st0   = ms;
        hs_pend = s_valid && rdy;
        mdone = 0;
        case (ms)
            0: if (s_valid) begin ms = 1; mlost = 0; iclk = 0; ibit = 0; first = 1; end
            1: begin
                if (ibit == idle_cfg) ms = 2;
                else if (!sense) begin iclk = 0; ibit = 0; end
                else if (iclk == P - 1) begin iclk = 0; ibit++; end
                else iclk++;
            end
            2: if (s_valid) begin msh = s_data; mlast = s_last; bitn = 0; ms = 3; mcnt = 0; end
            3: begin
                if (mcnt == samp_pt() && msh[7] && !sense) begin
                    mlost = 1; ms = mlast ? 0 : 4; mcnt = 0;
                end else if (mcnt == P - 1) begin
                    mcnt = 0;
                    if (bitn == 7) begin
                        if (mlast) begin ms = 0; mdone = 1; end
                        else if (s_valid) begin msh = s_data; mlast = s_last; bitn = 0; end
                        else ms = 2;
                    end else begin
                        msh = {msh[6:0], 1'b0}; bitn++;
                    end
                end else mcnt++;
            end
            4: if (s_valid && s_last) ms = 0;
            default: ms = 0;
        endcase
        if (comp_on) begin
            if (ccnt == samp_pt() && csh[7] && !sense) comp_on = 0;
            else if (ccnt == P - 1) begin
                ccnt = 0;
                if (cbit == 7) begin
                    if (comp_q.size() > 0) begin csh = comp_q.pop_front(); cbit = 0; end
                    else comp_on = 0;
                end else begin csh = {csh[6:0], 1'b0}; cbit++; end
            end else ccnt++;
        end
        if (st0 == 2 && ms == 3 && first) begin
            first = 0;
            if (comp_q.size() > 0) begin
                comp_on = 1; ccnt = 0; cbit = 0; csh = comp_q.pop_front();
            end
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            ms = 0; mcnt = 0; mlost = 0; mdone = 0; hs_pend = 0; comp_on = 0;
        end else if (!finished) begin
            model_step();
        end
        if (cyc == WDOG && !finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired at cycle %0d: act=running exp=finished", cyc);
            finish_run();
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2 R3", "bus_drive_low", bus_drive_low, exp_drive());
            chk("R11 R10 R6", "s_ready", s_ready, exp_ready());
            chk("R8", "busy", busy, (ms >= 1 && ms <= 3));
            chk("R7", "done", done, mdone);
            chk("R5 R9", "arb_lost", arb_lost, mlost);
            if (done) done_cnt++;
        end
        if (hs_pend) begin
            void'(up_q.pop_front());
            hs_pend = 0;
        end
        if (up_q.size() > 0) begin
            s_valid = 1'b1; s_data = up_q[0][7:0]; s_last = up_q[0][8];
        end else begin
            s_valid = 1'b0; s_data = '0; s_last = 1'b0;
        end
        oth_low = comp_on && (ccnt >= (csh[7] ? q3_pt() : half_pt()));
    end

    task automatic wait_idle();
        @(negedge clk);
        while (!(ms == 0 && up_q.size() == 0 && !hs_pend && !comp_on)) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        chk("R8", "busy in reset", busy, 1'b0);
        chk("R7", "done in reset", done, 1'b0);
        chk("R5", "arb_lost in reset", arb_lost, 1'b0);
        chk("R2", "bus_drive_low in reset", bus_drive_low, 1'b0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R2 R3: single byte with both bit values
        done_cnt = 0;
        up_q.push_back({1'b1, 8'hA5});
        wait_idle();
        chk("R7", "done pulses single byte", logic'(done_cnt == 1), 1'b1);

        // R1: three bytes back to back
        done_cnt = 0;
        up_q.push_back({1'b0, 8'h3C});
        up_q.push_back({1'b0, 8'h81});
        up_q.push_back({1'b1, 8'hFF});
        wait_idle();
        chk("R1", "done pulses three bytes", logic'(done_cnt == 1), 1'b1);

        // R10: upstream stalls between bytes
        up_q.push_back({1'b0, 8'h55});
        @(negedge clk);
        while (ms != 3) @(negedge clk);
        while (ms != 2) @(negedge clk);
        repeat (5) @(negedge clk);
        chk("R10", "line released while stalled", bus_drive_low, 1'b0);
        chk("R10", "ready held while stalled", s_ready, 1'b1);
        up_q.push_back({1'b1, 8'hC3});
        wait_idle();

        // R4: noise during the idle wait restarts the count
        up_q.push_back({1'b1, 8'h0F});
        @(negedge clk);
        while (ms != 1) @(negedge clk);
        repeat (10) @(negedge clk);
        noise_low = 1'b1;
        repeat (3) @(negedge clk);
        noise_low = 1'b0;
        repeat (P + 4) @(negedge clk);
        chk("R4", "still waiting after noise", logic'(ms == 1), 1'b1);
        wait_idle();

        // R5 R6: lose to a lower header mid-message
        done_cnt = 0;
        comp_q.push_back(8'h20);
        up_q.push_back({1'b0, 8'h40});
        up_q.push_back({1'b0, 8'h11});
        up_q.push_back({1'b1, 8'h22});
        wait_idle();
        chk("R5", "lost flag after defeat", arb_lost, 1'b1);
        chk("R8", "busy after defeat", busy, 1'b0);
        chk("R7", "no done after defeat", logic'(done_cnt == 0), 1'b1);
        chk("R6", "all bytes drained", logic'(up_q.size() == 0), 1'b1);

        // R9: flag sticks in idle, clears on the next attempt
        repeat (20) @(negedge clk);
        chk("R9", "lost flag sticky in idle", arb_lost, 1'b1);
        done_cnt = 0;
        up_q.push_back({1'b1, 8'h01});
        wait_idle();
        chk("R9", "lost flag cleared by new attempt", arb_lost, 1'b0);
        chk("R7", "done after retry", logic'(done_cnt == 1), 1'b1);

        // R5: win against a higher header
        done_cnt = 0;
        comp_q.push_back(8'h40);
        comp_q.push_back(8'h00);
        up_q.push_back({1'b1, 8'h20});
        wait_idle();
        chk("R5", "no loss when winning", arb_lost, 1'b0);
        chk("R7", "done when winning", logic'(done_cnt == 1), 1'b1);

        // R5: loss on the final byte returns straight to idle
        comp_q.push_back(8'h3F);
        up_q.push_back({1'b1, 8'h7F});
        wait_idle();
        chk("R5", "lost on final byte", arb_lost, 1'b1);

        // R1 R4: other period, no idle wait
        P = 24;
        idle_cfg = 0;
        repeat (2) @(negedge clk);
        done_cnt = 0;
        up_q.push_back({1'b0, 8'h96});
        up_q.push_back({1'b1, 8'h6B});
        wait_idle();
        chk("R1", "done with 24-clock period", logic'(done_cnt == 1), 1'b1);

        finish_run();
    end
endmodule